// File: doc/BRIEF.md
# Interrupt and Bus-Request Arbiter

This block chooses what a small processor core services next. There are three kinds of request. The first is an external bus request. The second is a non-maskable interrupt (NMI). The third is a set of maskable interrupt lines. All request pins are active low, and each passes through a synchronizer before any decision uses it. The core supplies two strobes: one marks the end of a machine cycle, the other the end of an instruction. Bus requests are taken at machine-cycle boundaries. Interrupts are taken only at instruction boundaries.

Each decision produces one grant pulse, one clock long. The grant goes to the bus handover, to NMI entry, or to one maskable line. While the bus is handed over, the acknowledge output stays low and no interrupt is taken. The acknowledge cycle of maskable line 0 drives the opcode-fetch strobe and the I/O strobe low together, so that a device can place a vector on the data bus. The other maskable lines are acknowledged without either strobe.

Top module: `irq_bus_arbiter`

## Requirements
- R1: After reset, every grant output is 0 and `busack_no`, `m1_no` and `iorq_no` are 1. The global interrupt enable is cleared, so a pending enabled maskable line is not granted until `ie_set_i` is pulsed.
- R2: Request pins pass through two flip-flop stages before arbitration. A bus request driven before a clock edge is granted no earlier than the third rising edge with `mc_end_i` high.
- R3: A bus request is granted only on a clock with `mc_end_i` high. `instr_end_i` alone does not grant it. The grant raises `bus_grant_o` and drives `busack_no` low, both in the clock after the strobe.
- R4: While the bus is handed over, no NMI or maskable grant is issued. `busack_no` returns to 1 once the synchronized bus request is released.
- R5: When a bus request and a latched NMI are eligible on the same strobe, only the bus is granted. The NMI stays pending and is granted after the bus is released.
- R6: A falling edge on `nmi_ni` is latched, so a one-clock pulse is not lost. The latch clears when the NMI is granted. A steady low level yields only one grant.
- R7: A pending NMI outranks every maskable line and is granted regardless of the global interrupt enable.
- R8: A grant of maskable line 0 (`int_grant_o` bit 0) drives `m1_no` and `iorq_no` low during the same clock as the grant.
- R9: Grants of maskable lines 1 and 2 (`int_grant_o` bits 1 and 2) leave `m1_no` and `iorq_no` at 1.
- R10: Among pending maskable lines whose `int_en_i` bit is 1, the lowest index wins. A line whose enable bit is 0 is skipped.
- R11: Any interrupt grant clears the global enable. No further maskable grant occurs until `ie_set_i` is pulsed again.
- R12: Each decision asserts exactly one grant output, for one clock only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busreq_ni | input | 1 | External bus request, active low |
| nmi_ni | input | 1 | Non-maskable interrupt, falling-edge sensed |
| int_ni | input | N_INT | Maskable interrupt requests, active low |
| int_en_i | input | N_INT | Per-line enable bits |
| ie_set_i | input | 1 | Sets the global interrupt enable |
| mc_end_i | input | 1 | Machine-cycle end strobe |
| instr_end_i | input | 1 | Instruction end strobe |
| bus_grant_o | output | 1 | Bus handover grant pulse |
| busack_no | output | 1 | Bus acknowledge, low while the bus is handed over |
| nmi_grant_o | output | 1 | NMI entry grant pulse |
| int_grant_o | output | N_INT | Maskable grant pulses, one bit per line |
| m1_no | output | 1 | Opcode-fetch strobe, low during the line 0 acknowledge |
| iorq_no | output | 1 | I/O strobe, low during the line 0 acknowledge |

## Verification
The assertions take two things for granted. First, the cycle strobes are well-formed single-clock signals from the core. Second, an interrupt grant can only follow a clock in which `instr_end_i` was high, and a bus grant only follows a clock in which `mc_end_i` was high. The stimulus respects this. It changes request pins only on falling clock edges. It holds every request at least four clocks before pulsing a strobe, so the synchronizer has settled. The only exception is the latency test, which deliberately strobes inside the synchronizer window.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {SEL_NONE, SEL_BUS, SEL_NMI, SEL_INT} sel_e;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_ni,
  output logic [W-1:0] q_no
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
    end else begin
      stage_q[0] <= d_ni;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_no = stage_q[STAGES-1];
endmodule

// File: rtl/arb_nmi_latch.sv
module arb_nmi_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_sn,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, pend_q;
  logic fall;

  assign fall = prev_q & ~nmi_sn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_sn;
      if (fall)       pend_q <= 1'b1;   // new edge wins over clear
      else if (clr_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import arb_pkg::*;
#(
  parameter int unsigned N_INT = 3
) (
  input  logic             busreq_i,
  input  logic             bus_held_i,
  input  logic             mc_end_i,
  input  logic             instr_end_i,
  input  logic             nmi_pend_i,
  input  logic             ie_i,
  input  logic [N_INT-1:0] int_act_i,
  input  logic [N_INT-1:0] int_en_i,
  output sel_e             sel_o,
  output logic [N_INT-1:0] int_sel_o
);
  logic [N_INT-1:0] cand;
  logic             intr_ok;

  assign cand    = int_act_i & int_en_i & {N_INT{ie_i}};
  assign intr_ok = instr_end_i & ~bus_held_i & ~busreq_i;

  always_comb begin
    int_sel_o = '0;
    for (int i = N_INT - 1; i >= 0; i--) begin
      if (cand[i]) int_sel_o = N_INT'(1) << i;
    end
    sel_o = SEL_NONE;
    if (!bus_held_i && busreq_i && mc_end_i) sel_o = SEL_BUS;
    else if (intr_ok && nmi_pend_i)          sel_o = SEL_NMI;
    else if (intr_ok && |cand)               sel_o = SEL_INT;
    if (sel_o != SEL_INT) int_sel_o = '0;
  end
endmodule

// File: rtl/irq_bus_arbiter.sv
module irq_bus_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned N_INT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busreq_ni,
  input  logic             nmi_ni,
  input  logic [N_INT-1:0] int_ni,
  input  logic [N_INT-1:0] int_en_i,
  input  logic             ie_set_i,
  input  logic             mc_end_i,
  input  logic             instr_end_i,
  output logic             bus_grant_o,
  output logic             busack_no,
  output logic             nmi_grant_o,
  output logic [N_INT-1:0] int_grant_o,
  output logic             m1_no,
  output logic             iorq_no
);
  localparam int unsigned SW = N_INT + 2;

  logic [SW-1:0]    req_sn;
  logic             busreq_s, nmi_pend, take_nmi, take_any_int;
  logic [N_INT-1:0] int_s, int_sel;
  logic             ie_q, bus_held_q;
  sel_e             sel;

  arb_sync #(.W(SW), .STAGES(SYNC_DEPTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_ni  ({busreq_ni, nmi_ni, int_ni}),
    .q_no  (req_sn)
  );

  assign busreq_s = ~req_sn[SW-1];
  assign int_s    = ~req_sn[N_INT-1:0];

  arb_nmi_latch u_nmi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .nmi_sn(req_sn[N_INT]),
    .clr_i (take_nmi),
    .pend_o(nmi_pend)
  );

  arb_pick #(.N_INT(N_INT)) u_pick (
    .busreq_i   (busreq_s),
    .bus_held_i (bus_held_q),
    .mc_end_i   (mc_end_i),
    .instr_end_i(instr_end_i),
    .nmi_pend_i (nmi_pend),
    .ie_i       (ie_q),
    .int_act_i  (int_s),
    .int_en_i   (int_en_i),
    .sel_o      (sel),
    .int_sel_o  (int_sel)
  );

  assign take_nmi     = (sel == SEL_NMI);
  assign take_any_int = take_nmi | (sel == SEL_INT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q        <= 1'b0;
      bus_held_q  <= 1'b0;
      bus_grant_o <= 1'b0;
      nmi_grant_o <= 1'b0;
      int_grant_o <= '0;
      m1_no       <= 1'b1;
      iorq_no     <= 1'b1;
    end else begin
      if (take_any_int)  ie_q <= 1'b0;
      else if (ie_set_i) ie_q <= 1'b1;

      if (sel == SEL_BUS)             bus_held_q <= 1'b1;
      else if (bus_held_q && !busreq_s) bus_held_q <= 1'b0;

      bus_grant_o <= (sel == SEL_BUS);
      nmi_grant_o <= take_nmi;
      int_grant_o <= int_sel;
      m1_no       <= ~int_sel[0];    // vectored acknowledge only on line 0
      iorq_no     <= ~int_sel[0];
    end
  end

  assign busack_no = ~bus_held_q;
endmodule

// File: rtl/irq_bus_arbiter_chk.sv
module irq_bus_arbiter_chk #(
  parameter int unsigned N_INT = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busreq_ni,
  input logic             nmi_ni,
  input logic [N_INT-1:0] int_ni,
  input logic [N_INT-1:0] int_en_i,
  input logic             ie_set_i,
  input logic             mc_end_i,
  input logic             instr_end_i,
  input logic             bus_grant_o,
  input logic             busack_no,
  input logic             nmi_grant_o,
  input logic [N_INT-1:0] int_grant_o,
  input logic             m1_no,
  input logic             iorq_no
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bus_grant_o, nmi_grant_o, int_grant_o})); // R12

  AST_BUS_AT_MC_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_grant_o |-> $past(mc_end_i)); // R3

  AST_BUS_ACK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_grant_o |-> !busack_no); // R3

  AST_IRQ_AT_INSTR_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_grant_o || |int_grant_o) |-> $past(instr_end_i)); // R4

  AST_NO_IRQ_WHILE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busack_no && !bus_grant_o) |-> (!nmi_grant_o && int_grant_o == '0)); // R4

  AST_INT0_ACK_STROBES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m1_no || !iorq_no) |-> (int_grant_o[0] && !m1_no && !iorq_no)); // R8

  AST_UPPER_ACK_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|int_grant_o[N_INT-1:1]) |-> (m1_no && iorq_no)); // R9

  AST_NMI_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_grant_o |=> !nmi_grant_o); // R12
endmodule

bind irq_bus_arbiter irq_bus_arbiter_chk #(.N_INT(N_INT)) u_chk (.*);

// File: tb/irq_bus_arbiter_test.sv
module irq_bus_arbiter_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       busreq_ni = 1'b1, nmi_ni = 1'b1;
  logic [2:0] int_ni = 3'b111, int_en_i = 3'b000;
  logic       ie_set_i = 1'b0, mc_end_i = 1'b0, instr_end_i = 1'b0;
  logic       bus_grant_o, busack_no, nmi_grant_o, m1_no, iorq_no;
  logic [2:0] int_grant_o;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  irq_bus_arbiter #(.N_INT(3)) uut (.*);

  always #10 clk_i = ~clk_i;

  // {bus_grant, nmi_grant, int_grant[2:0], busack_n, m1_n, iorq_n}
  function automatic logic [7:0] snap();
    return {bus_grant_o, nmi_grant_o, int_grant_o, busack_no, m1_no, iorq_no};
  endfunction

  localparam logic [7:0] IDLE = 8'b0_0_000_111;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic settle();
    tick(4);
  endtask

  task automatic pulse_ie();
    ie_set_i = 1'b1; tick(); ie_set_i = 1'b0;
  endtask

  // strobe for one rising edge, return outputs seen after it
  task automatic strobe(input logic mc, input logic ie_end, output logic [7:0] res);
    mc_end_i = mc; instr_end_i = ie_end;
    tick();
    res = snap();
    mc_end_i = 1'b0; instr_end_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] r;
    check(snap(), IDLE, "R1 reset idle");
    int_en_i = 3'b111; int_ni = 3'b110; settle();
    strobe(1'b0, 1'b1, r);
    check(r, IDLE, "R1 global enable clear after reset");
    int_ni = 3'b111; settle();
  endtask

  task automatic t_sync();
    busreq_ni = 1'b0; mc_end_i = 1'b1;
    tick(); check(snap(), IDLE, "R2 no grant after one edge");
    tick(); check(snap(), IDLE, "R2 no grant after two edges");
    tick(); check(snap(), 8'b1_0_000_011, "R2 grant on third edge");
    mc_end_i = 1'b0;
    busreq_ni = 1'b1; settle();
    check(snap(), IDLE, "R2 released");
  endtask

  task automatic t_bus();
    logic [7:0] r;
    busreq_ni = 1'b0; int_ni = 3'b110; pulse_ie(); settle();
    strobe(1'b0, 1'b1, r);
    check(r, IDLE, "R3 instr_end alone does not grant bus");
    strobe(1'b1, 1'b0, r);
    check(r, 8'b1_0_000_011, "R3 bus grant and busack low");
    tick(); check(snap(), 8'b0_0_000_011, "R12 bus grant one clock");
    strobe(1'b1, 1'b1, r);
    check(r, 8'b0_0_000_011, "R4 no interrupt while bus held");
    busreq_ni = 1'b1; settle();
    check(snap(), IDLE, "R4 busack released");
    int_ni = 3'b111; settle();
  endtask

  task automatic t_bus_vs_nmi();
    logic [7:0] r;
    busreq_ni = 1'b0; nmi_ni = 1'b0; settle();
    strobe(1'b1, 1'b1, r);
    check(r, 8'b1_0_000_011, "R5 bus beats NMI");
    busreq_ni = 1'b1; nmi_ni = 1'b1; settle();
    strobe(1'b0, 1'b1, r);
    check(r, 8'b0_1_000_111, "R5 NMI granted after release");
  endtask

  task automatic t_nmi();
    logic [7:0] r;
    nmi_ni = 1'b0; tick(); nmi_ni = 1'b1; settle();
    strobe(1'b0, 1'b1, r);
    check(r, 8'b0_1_000_111, "R6 short NMI pulse latched");
    strobe(1'b0, 1'b1, r);
    check(r, IDLE, "R6 latch cleared by grant");
    nmi_ni = 1'b0; settle();
    strobe(1'b0, 1'b1, r);
    check(r, 8'b0_1_000_111, "R6 level low grants once");
    strobe(1'b0, 1'b1, r);
    check(r, IDLE, "R6 steady low no regrant");
    nmi_ni = 1'b1; settle();
  endtask

  task automatic t_maskable();
    logic [7:0] r;
    int_en_i = 3'b111; int_ni = 3'b100;
    nmi_ni = 1'b0; tick(); nmi_ni = 1'b1; settle();
    strobe(1'b0, 1'b1, r);
    check(r, 8'b0_1_000_111, "R7 NMI over maskable, enable clear");
    pulse_ie();
    strobe(1'b0, 1'b1, r);
    check(r, 8'b0_0_001_100, "R8 line 0 ack with m1 and iorq low");
    tick(); check(snap(), IDLE, "R8 strobes return high");
    strobe(1'b0, 1'b1, r);
    check(r, IDLE, "R11 enable cleared by grant");
    pulse_ie();
    strobe(1'b0, 1'b1, r);
    check(r, 8'b0_0_001_100, "R10 line 0 beats line 1");
    int_en_i = 3'b110; pulse_ie();
    strobe(1'b0, 1'b1, r);
    check(r, 8'b0_0_010_111, "R9 R10 line 1 silent ack, line 0 masked");
    int_ni = 3'b010; settle(); pulse_ie();
    strobe(1'b0, 1'b1, r);
    check(r, 8'b0_0_100_111, "R9 line 2 silent ack");
    int_ni = 3'b111; settle();
  endtask

  initial begin
    tick(2); rst_ni = 1'b1; tick();
    t_reset();
    t_sync();
    t_bus();
    t_bus_vs_nmi();
    t_nmi();
    t_maskable();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule